// File: doc/BRIEF.md
# Interrupt and Reset Control Unit

This block sits beside an 8-bit processor core and decides, at the points where the core can be interrupted, what happens next. It tracks whether the reset input was held long enough. It grants the bus to an external master when one asks. It captures falling edges of the non-maskable request. It accepts the level-sensitive maskable request when the core has interrupts enabled.

When an interrupt is accepted, the block raises a one-cycle take pulse and presents a target. The target is a fixed restart address, a vector address assembled from the core's vector-base register and a byte read from the device, or a raw opcode byte that the core executes itself. The core uses the reset-complete flag to clear its program counter and its vector-base and refresh registers. It drives the end-of-instruction and end-of-machine-cycle strobes and issues the enable, disable and mode-select commands.

Top module: `irq_rst_ctrl`

## Requirements
- R1: `rst_done_o` is 0 while `reset_n_i` is sampled low. It becomes 1 one cycle after the first high sample that follows a run of at least MIN_RST (default 3) consecutive low samples. A shorter low run leaves it at 0, and while it is 0 nothing is taken or granted.
- R2: After a completed reset, `ie_o` is 0 and the maskable mode is opcode mode (code 0), so an interrupt accepted after only an enable command delivers an opcode.
- R3: A falling edge on `nmi_n_i` is latched. It is taken at the next sampled `instr_end_i` whatever `ie_o` holds, with `take_o`=1, `take_nmi_o`=1, `take_opc_o`=0 and `target_o`=0066h.
- R4: A low `int_n_i` is accepted only in a cycle where `instr_end_i` is sampled high and `ie_o` is 1. A low level at any other time has no effect.
- R5: When a latched NMI and an enabled INT meet at the same instruction end, the NMI is taken.
- R6: `busreq_n_i` sampled low together with `mcyc_end_i` sets `bus_grant_o` in the next cycle, and no interrupt is taken in that cycle. `instr_end_i` without `mcyc_end_i` grants nothing. `bus_grant_o` falls one cycle after `busreq_n_i` is sampled high, and no take happens while it is 1.
- R7: An NMI edge that arrives during a bus grant stays latched. It is taken at the first instruction end after the grant ends.
- R8: In mode 1 (code 1), an accepted INT gives `target_o`=0038h with `take_opc_o`=0, and the data byte is ignored.
- R9: In mode 2 (code 2), an accepted INT gives `target_o`={`ireg_i`, `ack_data_i`}.
- R10: In mode 0, an accepted INT gives `take_opc_o`=1 and `target_o`={00h, `ack_data_i`}.
- R11: Accepting either interrupt clears `ie_o`. `ei_i` sets it and `di_i` clears it, with disable winning over enable and acceptance winning over both.
- R12: `im_wr_i` with `im_code_i` of 0, 1 or 2 selects that mode. Code 3 leaves the mode unchanged.
- R13: All outputs are registered. A take appears in the cycle after the sampled instruction end and lasts one cycle for each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| reset_n_i | input | 1 | reset request, active low, sampled on the clock |
| int_n_i | input | 1 | maskable request, active-low level |
| busreq_n_i | input | 1 | external bus request, active low |
| nmi_n_i | input | 1 | non-maskable request, falling-edge sensitive |
| instr_end_i | input | 1 | core is at the last cycle of an instruction |
| mcyc_end_i | input | 1 | core is at the last cycle of a machine cycle |
| ei_i | input | 1 | enable-interrupts command |
| di_i | input | 1 | disable-interrupts command |
| im_wr_i | input | 1 | mode-select command strobe |
| im_code_i | input | 2 | requested mode code |
| ireg_i | input | 8 | vector-base register value from the core |
| ack_data_i | input | 8 | byte read from the device during acknowledge |
| take_o | output | 1 | interrupt accepted (one-cycle pulse) |
| take_nmi_o | output | 1 | the accepted interrupt is the NMI |
| take_opc_o | output | 1 | target low byte is an opcode, not an address |
| target_o | output | 16 | jump target or opcode |
| ie_o | output | 1 | interrupt-enable state |
| bus_grant_o | output | 1 | bus handed to the external master |
| rst_done_o | output | 1 | reset completed with sufficient length |

## Verification
Directed cases set up each of the three modes with distinct register and data bytes, so a wrong byte order or a wrong mode is visible in the target. Reset runs of two and of four low cycles separate a correct length check from an off-by-one. Collisions of NMI, INT and bus request at the same strobe separate the three priority levels, and an NMI edge placed inside a grant checks that it is held. A seeded random phase toggles every request and strobe independently and compares every output in every cycle with a bench model, which brings out interactions among enable, disable, mode writes and back-to-back NMI edges.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // data byte width of the core
    localparam int DATA_W = 8;

    // maskable interrupt mode codes, as written by the mode-select command
    typedef enum logic [1:0] {
        IM_OPC = 2'd0,   // opcode supplied by the device
        IM_FIX = 2'd1,   // fixed restart address
        IM_VEC = 2'd2    // vector table entry
    } im_e;

endpackage

// File: rtl/irqc_rst_len.sv
module irqc_rst_len #(
    parameter int MIN_LOW = 3
) (
    input  logic clk_i,
    input  logic reset_n_i,
    output logic done_o
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

    typedef struct packed {
        logic          low;   // previous sample was low
        logic [CW-1:0] cnt;   // length of current low run, saturating
        logic          done;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.low = ~reset_n_i;
        if (!reset_n_i) begin
            s_d.done = 1'b0;
            if (!s_q.low)
                s_d.cnt = CW'(1);
            else if (s_q.cnt != CMAX)
                s_d.cnt = s_q.cnt + CW'(1);
        end else if (s_q.low && s_q.cnt == CMAX) begin
            s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i) s_q <= s_d;

    assign done_o = s_q.done;
endmodule

// File: rtl/irqc_nmi_latch.sv
module irqc_nmi_latch (
    input  logic clk_i,
    input  logic clr_i,
    input  logic nmi_n_i,
    input  logic svc_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } st_t;

    st_t  s_d, s_q;
    logic fall;

    always_comb begin
        fall     = s_q.prev & ~nmi_n_i;
        s_d.prev = nmi_n_i;
        s_d.pend = fall | (s_q.pend & ~svc_i);
        if (clr_i) s_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i) s_q <= s_d;

    assign pend_o = s_q.pend;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter logic [2*DW-1:0] NMI_VEC = 16'h0066,
    parameter logic [2*DW-1:0] FIX_VEC = 16'h0038
) (
    input  logic          clk_i,
    input  logic          rst_act_i,
    input  logic          ready_i,
    input  logic          int_n_i,
    input  logic          busreq_n_i,
    input  logic          instr_end_i,
    input  logic          mcyc_end_i,
    input  logic          ei_i,
    input  logic          di_i,
    input  logic          im_wr_i,
    input  logic [1:0]    im_code_i,
    input  logic [DW-1:0] ireg_i,
    input  logic [DW-1:0] ack_i,
    input  logic          nmi_pend_i,
    output logic          nmi_svc_o,
    output logic          take_o,
    output logic          take_nmi_o,
    output logic          take_opc_o,
    output logic [2*DW-1:0] tgt_o,
    output logic          ie_o,
    output logic          grant_o
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        logic          ie;
        im_e           mode;
        logic          grant;
        logic          take;
        logic          nmi;
        logic          opc;
        logic [AW-1:0] tgt;
    } st_t;

    st_t  s_d, s_q;
    logic bus_win, at_end, take_nmi, take_int;

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;
        s_d.nmi  = 1'b0;
        s_d.opc  = 1'b0;

        // bus request outranks both interrupts and is seen at machine-cycle ends
        bus_win   = ready_i & mcyc_end_i & ~busreq_n_i;
        s_d.grant = ready_i & ~busreq_n_i & (s_q.grant | mcyc_end_i);

        at_end   = ready_i & ~s_q.grant & instr_end_i & ~bus_win;
        take_nmi = at_end & nmi_pend_i;
        take_int = at_end & ~nmi_pend_i & ~int_n_i & s_q.ie;

        if (ready_i && im_wr_i) begin
            case (im_code_i)
                2'd0:    s_d.mode = IM_OPC;
                2'd1:    s_d.mode = IM_FIX;
                2'd2:    s_d.mode = IM_VEC;
                default: s_d.mode = s_q.mode;
            endcase
        end

        if (ready_i && ei_i) s_d.ie = 1'b1;
        if (ready_i && di_i) s_d.ie = 1'b0;

        if (take_nmi) begin
            s_d.take = 1'b1;
            s_d.nmi  = 1'b1;
            s_d.ie   = 1'b0;
            s_d.tgt  = NMI_VEC;
        end else if (take_int) begin
            s_d.take = 1'b1;
            s_d.ie   = 1'b0;
            case (s_q.mode)
                IM_OPC: begin
                    s_d.opc = 1'b1;
                    s_d.tgt = {{DW{1'b0}}, ack_i};
                end
                IM_VEC:  s_d.tgt = {ireg_i, ack_i};
                default: s_d.tgt = FIX_VEC;
            endcase
        end

        if (rst_act_i) begin
            s_d      = '0;
            s_d.mode = IM_OPC;
        end
    end

    always_ff @(posedge clk_i) s_q <= s_d;

    assign nmi_svc_o  = take_nmi;
    assign take_o     = s_q.take;
    assign take_nmi_o = s_q.nmi;
    assign take_opc_o = s_q.opc;
    assign tgt_o      = s_q.tgt;
    assign ie_o       = s_q.ie;
    assign grant_o    = s_q.grant;
endmodule

// File: rtl/irq_rst_ctrl.sv
module irq_rst_ctrl
    import irqc_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int MIN_RST = 3,
    parameter logic [2*DW-1:0] NMI_VEC = 16'h0066,
    parameter logic [2*DW-1:0] FIX_VEC = 16'h0038
) (
    input  logic            clk_i,
    input  logic            reset_n_i,
    input  logic            int_n_i,
    input  logic            busreq_n_i,
    input  logic            nmi_n_i,
    input  logic            instr_end_i,
    input  logic            mcyc_end_i,
    input  logic            ei_i,
    input  logic            di_i,
    input  logic            im_wr_i,
    input  logic [1:0]      im_code_i,
    input  logic [DW-1:0]   ireg_i,
    input  logic [DW-1:0]   ack_data_i,
    output logic            take_o,
    output logic            take_nmi_o,
    output logic            take_opc_o,
    output logic [2*DW-1:0] target_o,
    output logic            ie_o,
    output logic            bus_grant_o,
    output logic            rst_done_o
);
    logic rst_act, ready, nmi_pend, nmi_svc;

    assign rst_act = ~reset_n_i;

    irqc_rst_len #(.MIN_LOW(MIN_RST)) u_len (
        .clk_i     (clk_i),
        .reset_n_i (reset_n_i),
        .done_o    (ready)
    );

    irqc_nmi_latch u_nmi (
        .clk_i   (clk_i),
        .clr_i   (rst_act),
        .nmi_n_i (nmi_n_i),
        .svc_i   (nmi_svc),
        .pend_o  (nmi_pend)
    );

    irqc_arb #(.DW(DW), .NMI_VEC(NMI_VEC), .FIX_VEC(FIX_VEC)) u_arb (
        .clk_i       (clk_i),
        .rst_act_i   (rst_act),
        .ready_i     (ready),
        .int_n_i     (int_n_i),
        .busreq_n_i  (busreq_n_i),
        .instr_end_i (instr_end_i),
        .mcyc_end_i  (mcyc_end_i),
        .ei_i        (ei_i),
        .di_i        (di_i),
        .im_wr_i     (im_wr_i),
        .im_code_i   (im_code_i),
        .ireg_i      (ireg_i),
        .ack_i       (ack_data_i),
        .nmi_pend_i  (nmi_pend),
        .nmi_svc_o   (nmi_svc),
        .take_o      (take_o),
        .take_nmi_o  (take_nmi_o),
        .take_opc_o  (take_opc_o),
        .tgt_o       (target_o),
        .ie_o        (ie_o),
        .grant_o     (bus_grant_o)
    );

    assign rst_done_o = ready;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int MIN_RST = 3,
    parameter logic [15:0] NMI_VEC = 16'h0066
) (
    input logic        clk_i,
    input logic        reset_n_i,
    input logic        int_n_i,
    input logic        busreq_n_i,
    input logic        instr_end_i,
    input logic        mcyc_end_i,
    input logic        take_o,
    input logic        take_nmi_o,
    input logic        take_opc_o,
    input logic [15:0] target_o,
    input logic        ie_o,
    input logic        bus_grant_o,
    input logic        rst_done_o
);
    localparam int RW = $clog2(MIN_RST + 1) + 1;
    logic          low_q = 1'b0;
    logic [RW-1:0] run_q = '0;

    always_ff @(posedge clk_i) begin
        low_q <= ~reset_n_i;
        if (!reset_n_i) begin
            if (!low_q)
                run_q <= RW'(1);
            else if (run_q != {RW{1'b1}})
                run_q <= run_q + RW'(1);
        end
    end

    // R1
    rst_len_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        $rose(rst_done_o) |-> (run_q >= RW'(MIN_RST)));

    // R13
    take_at_end_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        take_o |-> $past(instr_end_i));

    // R11
    take_clears_ie_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        take_o |-> !ie_o);

    // R4
    int_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        (take_o && !take_nmi_o) |-> ($past(ie_o) && !$past(int_n_i)));

    // R6
    grant_rise_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        $rose(bus_grant_o) |-> ($past(mcyc_end_i) && !$past(busreq_n_i)));

    // R6
    no_take_in_grant_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        !(take_o && bus_grant_o));

    // R3
    nmi_target_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        take_nmi_o |-> (take_o && !take_opc_o && target_o == NMI_VEC));

    // R1
    no_take_before_done_chk: assert property (@(posedge clk_i) disable iff (!reset_n_i)
        take_o |-> $past(rst_done_o));
endmodule

bind irq_rst_ctrl irqc_chk #(.MIN_RST(MIN_RST)) chk_i (
    .clk_i       (clk_i),
    .reset_n_i   (reset_n_i),
    .int_n_i     (int_n_i),
    .busreq_n_i  (busreq_n_i),
    .instr_end_i (instr_end_i),
    .mcyc_end_i  (mcyc_end_i),
    .take_o      (take_o),
    .take_nmi_o  (take_nmi_o),
    .take_opc_o  (take_opc_o),
    .target_o    (target_o),
    .ie_o        (ie_o),
    .bus_grant_o (bus_grant_o),
    .rst_done_o  (rst_done_o)
);

// File: tb/irq_rst_ctrl_tb.sv
module irq_rst_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic reset_n = 1'b0, int_n = 1'b1, busreq_n = 1'b1, nmi_n = 1'b1;
    logic instr_end = 1'b0, mcyc_end = 1'b0, ei = 1'b0, di = 1'b0, im_wr = 1'b0;
    logic [1:0]  im_code = 2'd0;
    logic [7:0]  ireg = 8'h00, ack = 8'h00;
    logic        take, tnmi, topc, ie, grant, done;
    logic [15:0] tgt;

    int n_chk = 0, n_fail = 0;

    // bench model state for the random phase
    logic m_ie, m_pend, m_prev, m_grant;
    logic [1:0] m_mode;
    logic e_take, e_nmi, e_opc;
    logic [15:0] e_tgt;

    always #(CLK_P/2) clk = ~clk;

    irq_rst_ctrl dut_i (
        .clk_i(clk), .reset_n_i(reset_n), .int_n_i(int_n), .busreq_n_i(busreq_n),
        .nmi_n_i(nmi_n), .instr_end_i(instr_end), .mcyc_end_i(mcyc_end),
        .ei_i(ei), .di_i(di), .im_wr_i(im_wr), .im_code_i(im_code),
        .ireg_i(ireg), .ack_data_i(ack), .take_o(take), .take_nmi_o(tnmi),
        .take_opc_o(topc), .target_o(tgt), .ie_o(ie), .bus_grant_o(grant),
        .rst_done_o(done)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_cmd(input logic e, input logic d);
        ei = e; di = d; tick(); ei = 1'b0; di = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] c);
        im_wr = 1'b1; im_code = c; tick(); im_wr = 1'b0;
    endtask

    task automatic full_reset();
        reset_n = 1'b0;
        repeat (4) tick();
        reset_n = 1'b1;
        tick();
    endtask

    function automatic logic [15:0] exp_target(input logic [1:0] mode,
                                               input logic [7:0] ir, input logic [7:0] d);
        case (mode)
            2'd0:    return {8'h00, d};
            2'd2:    return {ir, d};
            default: return 16'h0038;
        endcase
    endfunction

    task automatic model_step();
        logic fall, at, tn, ti, ng;
        fall = m_prev & ~nmi_n;
        at   = ~m_grant & instr_end & ~(mcyc_end & ~busreq_n);
        tn   = at & m_pend;
        ti   = at & ~m_pend & ~int_n & m_ie;
        e_take = tn | ti;
        e_nmi  = tn;
        e_opc  = ti & (m_mode == 2'd0);
        e_tgt  = tn ? 16'h0066 : exp_target(m_mode, ireg, ack);
        ng     = ~busreq_n & (m_grant | mcyc_end);
        m_pend = fall | (m_pend & ~tn);
        if (im_wr && im_code != 2'd3) m_mode = im_code;
        if (ei) m_ie = 1'b1;
        if (di) m_ie = 1'b0;
        if (tn | ti) m_ie = 1'b0;
        m_grant = ng;
        m_prev  = nmi_n;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // reset state, R1 R2
        repeat (3) tick();
        chk("R1", "done during reset", done, 0);
        chk("R2", "ie after reset", ie, 0);
        chk("R1", "take during reset", take, 0);
        reset_n = 1'b1; tick();
        chk("R1", "done after 3 low", done, 1);

        // short reset: two low samples
        reset_n = 1'b0; tick(); tick();
        reset_n = 1'b1; busreq_n = 1'b0; mcyc_end = 1'b1; tick(); tick();
        chk("R1", "done after short reset", done, 0);
        chk("R1", "no grant before done", grant, 0);
        busreq_n = 1'b1; mcyc_end = 1'b0;
        full_reset();
        chk("R1", "done after 4 low", done, 1);

        // default mode 0, R2 R10 R11
        pulse_cmd(1'b1, 1'b0);
        chk("R11", "ie after enable", ie, 1);
        int_n = 1'b0; ack = 8'hFF; instr_end = 1'b1; mcyc_end = 1'b1; tick();
        chk("R10", "take mode0", take, 1);
        chk("R10", "opcode flag", topc, 1);
        chk("R2", "opcode target", tgt, 16'h00FF);
        chk("R11", "ie cleared on take", ie, 0);
        tick();
        chk("R4", "masked INT", take, 0);
        chk("R13", "single pulse", take, 0);
        instr_end = 1'b0; mcyc_end = 1'b0;

        // INT level without instruction end
        pulse_cmd(1'b1, 1'b0); tick(); tick();
        chk("R4", "no take without instr end", take, 0);

        // mode 1
        set_mode(2'd1);
        ack = 8'h55; instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R8", "mode1 take", take, 1);
        chk("R8", "mode1 target", tgt, 16'h0038);
        chk("R8", "mode1 opc flag", topc, 0);

        // mode 2
        set_mode(2'd2); ireg = 8'h12; pulse_cmd(1'b1, 1'b0);
        ack = 8'h34; instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R9", "mode2 target", tgt, 16'h1234);

        // code 3 ignored
        set_mode(2'd3); pulse_cmd(1'b1, 1'b0);
        ireg = 8'hAB; ack = 8'hCD; instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R12", "mode kept after code 3", tgt, 16'hABCD);

        // enable / disable ordering
        int_n = 1'b1;
        pulse_cmd(1'b1, 1'b1);
        chk("R11", "disable beats enable", ie, 0);
        pulse_cmd(1'b1, 1'b0);
        pulse_cmd(1'b0, 1'b1);
        chk("R11", "disable clears", ie, 0);

        // NMI with interrupts disabled
        nmi_n = 1'b0; tick(); nmi_n = 1'b1; tick(); tick();
        chk("R3", "NMI waits for instr end", take, 0);
        instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R3", "NMI take", take, 1);
        chk("R3", "NMI flag", tnmi, 1);
        chk("R3", "NMI target", tgt, 16'h0066);
        tick();
        chk("R3", "NMI latch cleared", take, 0);

        // NMI beats INT
        pulse_cmd(1'b1, 1'b0); int_n = 1'b0;
        nmi_n = 1'b0; tick(); nmi_n = 1'b1;
        instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R5", "NMI first", tnmi, 1);
        chk("R11", "ie after NMI", ie, 0);

        // NMI edge during grant
        busreq_n = 1'b0; mcyc_end = 1'b1; tick(); mcyc_end = 1'b0;
        chk("R6", "grant set", grant, 1);
        nmi_n = 1'b0; tick(); nmi_n = 1'b1;
        instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R6", "no take while granted", take, 0);
        busreq_n = 1'b1; tick();
        chk("R6", "grant released", grant, 0);
        instr_end = 1'b1; mcyc_end = 1'b1; tick(); instr_end = 1'b0; mcyc_end = 1'b0;
        chk("R7", "held NMI taken", tnmi, 1);

        // instruction end alone does not grant
        busreq_n = 1'b0; instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R6", "no grant without mcyc end", grant, 0);
        busreq_n = 1'b1;

        // bus beats INT at a shared end
        pulse_cmd(1'b1, 1'b0);
        busreq_n = 1'b0; instr_end = 1'b1; mcyc_end = 1'b1; tick();
        chk("R6", "bus wins grant", grant, 1);
        chk("R6", "bus wins no take", take, 0);
        chk("R6", "ie kept", ie, 1);
        instr_end = 1'b0; mcyc_end = 1'b0; busreq_n = 1'b1; tick();
        instr_end = 1'b1; mcyc_end = 1'b1; ireg = 8'h3C; ack = 8'h5A; tick();
        instr_end = 1'b0; mcyc_end = 1'b0;
        chk("R5", "INT after bus", take, 1);
        chk("R9", "INT after bus target", tgt, 16'h3C5A);
        int_n = 1'b1;

        // random phase against bench model
        full_reset();
        m_ie = 1'b0; m_pend = 1'b0; m_prev = nmi_n; m_grant = 1'b0; m_mode = 2'd0;
        for (int k = 0; k < 2000; k++) begin
            int_n = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 5) == 0) nmi_n = ~nmi_n;
            if ($urandom_range(0, 7) == 0) busreq_n = ~busreq_n;
            instr_end = ($urandom_range(0, 3) == 0);
            mcyc_end  = instr_end | 1'($urandom_range(0, 1));
            ei    = ($urandom_range(0, 7) == 0);
            di    = ($urandom_range(0, 11) == 0);
            im_wr = ($urandom_range(0, 9) == 0);
            im_code = 2'($urandom_range(0, 3));
            ireg = 8'($urandom); ack = 8'($urandom);
            model_step();
            tick();
            chk("R13", "random take", take, e_take);
            chk("R5", "random nmi flag", tnmi, e_nmi);
            chk("R10", "random opc flag", topc, e_opc);
            chk("R11", "random ie", ie, m_ie);
            chk("R6", "random grant", grant, m_grant);
            if (e_take) chk("R9", "random target", tgt, e_tgt);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule